// File: doc/BRIEF.md
# Data Watchpoint Comparator Bank

This block holds a parameterised set of data watchpoint units and observes every load and store that the core issues. Each unit keeps a watched address and a control word. An access matches a unit when the unit is enabled, the access direction is allowed by the unit, the access is not an instruction fetch, and at least one byte that the access covers lies inside the unit's watched range. The range is the watched address with a chosen number of low bits ignored. A unit can also be tied to one of several context-match signals that linked breakpoint comparators produce. The unit then matches only while that signal is high.

The bank reports the lowest-numbered matching unit one clock after the access. Together with that index it reports the data address of the access, so that the exception logic can record it as the faulting address. Software programs the units through a simple write port that selects a unit and chooses between its address register and its control register.

Top module: `wp_bank`

## Requirements
- R1: After reset `wp_hit`, `wp_idx` and `wp_addr` are zero and every unit is disabled, so no access produces an event until a unit has been programmed.
- R2: `N_UNITS` is a parameter from 2 to 16. Bit 0 of a unit's control word enables that unit, and a unit whose enable bit is clear never matches.
- R3: Control bits [7:3] hold a mask count m. For m from 3 to 31 the low m address bits are ignored, so the unit watches the aligned 2^m-byte block that holds the watched address. The values 0, 1 and 2 watch one byte: the exact watched address.
- R4: Control bits [2:1] select the direction. 2'b01 allows reads only, 2'b10 allows writes only, 2'b11 allows both, and 2'b00 makes the unit never match. `acc_write` high marks a store.
- R5: An access with `acc_fetch` high never produces an event, whatever the configuration.
- R6: When control bit 8 is set, the unit matches only while `ctx_match[s]` is high, where s is control bits [12:9]. A value of s that is not below `CTX_N` makes the unit never match.
- R7: An access of size code k covers the 2^k bytes from `acc_addr` upward. It matches when any of those bytes lies in the watched range.
- R8: An access with `acc_valid` high at clock edge t produces `wp_hit` high after edge t. At the same time `wp_idx` is the lowest index among the matching units and `wp_addr` is that access's address.
- R9: A cycle in which `acc_valid` is low produces `wp_hit` low in the next cycle.
- R10: A write with `cfg_we` high stores `cfg_wdata` into the unit numbered `cfg_unit`: into its control word when `cfg_ctl_sel` is 1, or into its watched address when it is 0. The new setting applies from the next cycle. A write to a unit number of `N_UNITS` or more changes no unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctl_sel | input | 1 | 1 selects the control word, 0 selects the watched address |
| cfg_unit | input | 4 | Unit number to write |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | A data access is observed this cycle |
| acc_addr | input | ADDR_W | Lowest byte address of the access |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_size | input | SIZE_W | Size code: the access spans 2^acc_size bytes |
| acc_fetch | input | 1 | The access is an instruction fetch |
| ctx_match | input | CTX_N | Context-match results from linked breakpoint units |
| wp_hit | output | 1 | Watchpoint event, one cycle after the access |
| wp_idx | output | IDX_W | Index of the lowest matching unit |
| wp_addr | output | ADDR_W | Data address to report as the fault address |

## Verification
The assertions take for granted that the observation port and the configuration port are driven with settled values at every rising edge, and that a unit whose configuration is written in a cycle is only compared in later cycles. They also assume that `acc_fetch` and `acc_valid` keep their meaning while the access is on the port. The stimulus changes inputs only on falling edges. It drives configuration writes and accesses in separate cycles. It draws accesses near the programmed addresses, so that hits, misses and multi-unit overlaps all occur under one fixed seed.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic [1:0] {
      DIR_NEVER = 2'b00,
      DIR_LOAD  = 2'b01,
      DIR_STORE = 2'b10,
      DIR_ANY   = 2'b11
   } wp_dir_e;

   // Control word: [12:9] link select, [8] link enable, [7:3] mask count,
   // [2:1] direction, [0] enable.
   typedef struct packed {
      logic [3:0] link_sel;
      logic       link_en;
      logic [4:0] mask;
      wp_dir_e    dir;
      logic       en;
   } wp_ctl_t;

   localparam int CTL_W    = $bits(wp_ctl_t);
   localparam int LINK_MAX = 16;
   localparam int MASK_MIN = 3;

   // Counts below the minimum mean that a single byte is watched.
   function automatic logic [4:0] mask_eff(input logic [4:0] m);
      return (m < 5'(MASK_MIN)) ? 5'd0 : m;
   endfunction

endpackage

// File: rtl/wp_range_match.sv
module wp_range_match
   import wp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [4:0]        mask,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              overlap
);
   // One extra bit so the last byte of an access at the top of the space
   // does not wrap.
   localparam int EW = ADDR_W + 1;

   logic [4:0]    m_eff;
   logic [EW-1:0] low_ones;
   logic [EW-1:0] win_lo;
   logic [EW-1:0] win_hi;
   logic [EW-1:0] acc_lo;
   logic [EW-1:0] acc_hi;

   always_comb begin
      m_eff    = mask_eff(mask);
      low_ones = (EW'(1) << m_eff) - EW'(1);
      win_lo   = {1'b0, base} & ~low_ones;
      win_hi   = win_lo | low_ones;
      acc_lo   = {1'b0, addr};
      acc_hi   = acc_lo + ((EW'(1) << size) - EW'(1));
      // R3 R7: the byte span of the access intersects the window
      overlap  = (acc_lo <= win_hi) && (acc_hi >= win_lo);
   end

endmodule

// File: rtl/wp_unit.sv
module wp_unit
   import wp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2,
   parameter int CTX_N  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_val,
   input  logic              we_ctl,
   input  logic [ADDR_W-1:0] val_wdata,
   input  wp_ctl_t           ctl_wdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic              acc_fetch,
   input  logic [CTX_N-1:0]  ctx_match,
   output logic              match_o
);
   logic [ADDR_W-1:0]   val_q;
   wp_ctl_t             ctl_q;
   logic                in_range;
   logic                dir_ok;
   logic                link_ok;
   logic [LINK_MAX-1:0] ctx_pad;

   // R10: per-unit registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         ctl_q <= '0;
      end else begin
         if (we_val) val_q <= val_wdata;
         if (we_ctl) ctl_q <= ctl_wdata;
      end
   end

   wp_range_match #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W)
   ) u_range (
      .base    (val_q),
      .mask    (ctl_q.mask),
      .addr    (acc_addr),
      .size    (acc_size),
      .overlap (in_range)
   );

   always_comb begin
      // R4: direction filter
      dir_ok  = acc_write ? ctl_q.dir[1] : ctl_q.dir[0];
      // R6: zero padding makes a select past CTX_N never true
      ctx_pad = LINK_MAX'(ctx_match);
      link_ok = !ctl_q.link_en || ctx_pad[ctl_q.link_sel];
      // R2 R5
      match_o = acc_valid && !acc_fetch && ctl_q.en && dir_ok && link_ok && in_range;
   end

   // R5
   unit_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> (acc_valid && !acc_fetch));

   // R2
   unit_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_ctl && !ctl_wdata.en) |=> !match_o);

endmodule

// File: rtl/wp_prio.sv
module wp_prio #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   // R8: lowest index wins
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IDX_W'(i);
            any    = 1'b1;
         end
      end
   end

   // R8
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R8
   gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);

   // R8
   gnt_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt - N'(1)) & req) == '0);

   // R8
   gnt_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (any && gnt[idx]));

endmodule

// File: rtl/wp_bank.sv
module wp_bank
   import wp_pkg::*;
#(
   parameter int N_UNITS = 8,
   parameter int ADDR_W  = 32,
   parameter int SIZE_W  = 2,
   parameter int CTX_N   = 4,
   localparam int IDX_W  = $clog2(N_UNITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_ctl_sel,
   input  logic [3:0]        cfg_unit,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic              acc_fetch,
   input  logic [CTX_N-1:0]  ctx_match,
   output logic              wp_hit,
   output logic [IDX_W-1:0]  wp_idx,
   output logic [ADDR_W-1:0] wp_addr
);
   // Elaboration checks on the parameters
   if (N_UNITS < 2 || N_UNITS > 16) begin : g_bad_units
      $error("wp_bank: N_UNITS must be 2..16");
   end
   if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr
      $error("wp_bank: ADDR_W must be 32..64");
   end
   if (SIZE_W < 1 || SIZE_W > 3) begin : g_bad_size
      $error("wp_bank: SIZE_W must be 1..3");
   end
   if (CTX_N < 1 || CTX_N > LINK_MAX) begin : g_bad_ctx
      $error("wp_bank: CTX_N must be 1..16");
   end

   logic [N_UNITS-1:0] unit_hit;
   logic [N_UNITS-1:0] unit_gnt;
   logic [IDX_W-1:0]   sel_idx;
   logic               sel_any;
   wp_ctl_t            ctl_word;

   assign ctl_word = wp_ctl_t'(cfg_wdata[CTL_W-1:0]);

   for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
      logic hit_me;
      // R10: unit numbers past N_UNITS decode to no unit
      assign hit_me = cfg_we && (cfg_unit == 4'(u));

      wp_unit #(
         .ADDR_W (ADDR_W),
         .SIZE_W (SIZE_W),
         .CTX_N  (CTX_N)
      ) u_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .we_val    (hit_me && !cfg_ctl_sel),
         .we_ctl    (hit_me && cfg_ctl_sel),
         .val_wdata (cfg_wdata),
         .ctl_wdata (ctl_word),
         .acc_valid (acc_valid),
         .acc_addr  (acc_addr),
         .acc_write (acc_write),
         .acc_size  (acc_size),
         .acc_fetch (acc_fetch),
         .ctx_match (ctx_match),
         .match_o   (unit_hit[u])
      );
   end

   wp_prio #(
      .N     (N_UNITS),
      .IDX_W (IDX_W)
   ) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (unit_hit),
      .gnt   (unit_gnt),
      .idx   (sel_idx),
      .any   (sel_any)
   );

   // R1 R8: one register stage for the event
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_hit  <= 1'b0;
         wp_idx  <= '0;
         wp_addr <= '0;
      end else begin
         wp_hit  <= sel_any;
         wp_idx  <= sel_any ? sel_idx : '0;
         wp_addr <= sel_any ? acc_addr : '0;
      end
   end

   // R5
   no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> $past(acc_valid && !acc_fetch));

   // R8
   addr_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> (wp_addr == $past(acc_addr)));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !wp_hit);

   // R8
   idx_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_any |=> (wp_hit && wp_idx == $past(sel_idx)));

endmodule

// File: tb/tb_wp_bank.sv
module tb_wp_bank;
   localparam int N  = 8;
   localparam int AW = 32;
   localparam int SW = 2;
   localparam int CN = 4;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_ctl_sel = 1'b0;
   logic [3:0]    cfg_unit = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_write = 1'b0;
   logic [SW-1:0] acc_size = '0;
   logic          acc_fetch = 1'b0;
   logic [CN-1:0] ctx_match = '0;
   logic          wp_hit;
   logic [IW-1:0] wp_idx;
   logic [AW-1:0] wp_addr;

   always #10 clk = ~clk;

   wp_bank #(.N_UNITS(N), .ADDR_W(AW), .SIZE_W(SW), .CTX_N(CN)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctl_sel(cfg_ctl_sel),
      .cfg_unit(cfg_unit), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_write(acc_write), .acc_size(acc_size),
      .acc_fetch(acc_fetch), .ctx_match(ctx_match), .wp_hit(wp_hit),
      .wp_idx(wp_idx), .wp_addr(wp_addr)
   );

   logic [AW-1:0] val_m [N];
   logic [12:0]   ctl_m [N];
   int n_cmp = 0;
   int n_bad = 0;

   // Control word from the field positions of R2 R3 R4 R6
   function automatic logic [12:0] mk_ctl(bit en, logic [1:0] dir, int m,
                                          bit lnk, int sel);
      return {4'(sel), lnk, 5'(m), dir, en};
   endfunction

   function automatic bit unit_ok(int u, logic [AW-1:0] a, bit wr, int sz,
                                  bit fe, logic [CN-1:0] cx);
      logic [12:0] c;
      longint m, lo, hi, alo, ahi;
      int s;
      c = ctl_m[u];
      if (!c[0] || fe) return 0;
      if (wr ? !c[2] : !c[1]) return 0;
      if (c[8]) begin
         s = int'(c[12:9]);
         if (s >= CN) return 0;
         if (!cx[s]) return 0;
      end
      m = longint'(c[7:3]);
      if (m < 3) m = 0;
      lo  = longint'(val_m[u]) & ~((64'sd1 << m) - 1);
      hi  = lo + (64'sd1 << m) - 1;
      alo = longint'(a);
      ahi = alo + (64'sd1 << sz) - 1;
      return (alo <= hi) && (ahi >= lo);
   endfunction

   task automatic check(bit ok, string req, string act, string exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   task automatic cfg(int u, bit is_ctl, logic [AW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ctl_sel = is_ctl; cfg_unit = 4'(u); cfg_wdata = d;
      if (u < N) begin
         if (is_ctl) ctl_m[u] = d[12:0];
         else val_m[u] = d;
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic access(logic [AW-1:0] a, bit wr, int sz, bit fe,
                         logic [CN-1:0] cx, string req);
      bit eh;
      int ei;
      eh = 0; ei = 0;
      for (int u = N - 1; u >= 0; u--)
         if (unit_ok(u, a, wr, sz, fe, cx)) begin eh = 1; ei = u; end
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = wr;
      acc_size = SW'(sz); acc_fetch = fe; ctx_match = cx;
      @(negedge clk);
      acc_valid = 1'b0;
      check((wp_hit == eh) && (!eh || (wp_idx == IW'(ei) && wp_addr == a)), req,
            $sformatf("hit=%0d idx=%0d addr=%h", wp_hit, wp_idx, wp_addr),
            $sformatf("hit=%0d idx=%0d addr=%h", eh, ei, eh ? a : '0));
   endtask

   bit done = 0;
   initial begin
      #(20 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a;
      int u;
      for (int i = 0; i < N; i++) begin val_m[i] = '0; ctl_m[i] = '0; end
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(wp_hit == 0 && wp_idx == 0 && wp_addr == 0, "R1",
            $sformatf("%0d/%0d/%h", wp_hit, wp_idx, wp_addr), "0/0/0");
      access(32'h0, 0, 0, 0, '0, "R1 disabled after reset");

      // Exact byte and size coverage (R3, R7)
      cfg(0, 0, 32'h1000);
      cfg(0, 1, 32'(mk_ctl(1, 2'b11, 0, 0, 0)));
      access(32'h1000, 0, 0, 0, '0, "R3 exact hit");
      access(32'h1001, 0, 0, 0, '0, "R3 exact miss");
      access(32'h0FFF, 1, 1, 0, '0, "R7 halfword reaches");
      access(32'h0FFE, 1, 1, 0, '0, "R7 halfword short");
      cfg(0, 1, 32'(mk_ctl(1, 2'b11, 2, 0, 0)));
      access(32'h1002, 0, 0, 0, '0, "R3 reserved mask 2");
      cfg(0, 1, 32'(mk_ctl(1, 2'b11, 4, 0, 0)));
      access(32'h100F, 0, 0, 0, '0, "R3 mask4 top");
      access(32'h1010, 0, 0, 0, '0, "R3 mask4 beyond");
      access(32'h0FF8, 0, 3, 0, '0, "R7 dword before");
      access(32'h0FF9, 0, 3, 0, '0, "R7 dword straddle");

      // Direction (R4) and fetch (R5)
      cfg(0, 1, 32'(mk_ctl(1, 2'b01, 0, 0, 0)));
      access(32'h1000, 1, 0, 0, '0, "R4 load-only store");
      access(32'h1000, 0, 0, 0, '0, "R4 load-only load");
      cfg(0, 1, 32'(mk_ctl(1, 2'b10, 0, 0, 0)));
      access(32'h1000, 0, 0, 0, '0, "R4 store-only load");
      access(32'h1000, 1, 0, 0, '0, "R4 store-only store");
      cfg(0, 1, 32'(mk_ctl(1, 2'b00, 0, 0, 0)));
      access(32'h1000, 1, 0, 0, '0, "R4 never");
      cfg(0, 1, 32'(mk_ctl(1, 2'b11, 0, 0, 0)));
      access(32'h1000, 0, 0, 1, '0, "R5 fetch");

      // Linking (R6)
      cfg(0, 1, 32'(mk_ctl(1, 2'b11, 0, 1, 2)));
      access(32'h1000, 0, 0, 0, 4'b1011, "R6 context low");
      access(32'h1000, 0, 0, 0, 4'b0100, "R6 context high");
      cfg(0, 1, 32'(mk_ctl(1, 2'b11, 0, 1, 5)));
      access(32'h1000, 0, 0, 0, 4'b1111, "R6 select out of range");

      // Priority and enable (R8, R2)
      cfg(3, 0, 32'h2000);
      cfg(3, 1, 32'(mk_ctl(1, 2'b11, 5, 0, 0)));
      cfg(5, 0, 32'h2004);
      cfg(5, 1, 32'(mk_ctl(1, 2'b11, 0, 0, 0)));
      access(32'h2004, 1, 2, 0, '0, "R8 lowest index");
      cfg(3, 1, 32'(mk_ctl(0, 2'b11, 5, 0, 0)));
      access(32'h2004, 1, 2, 0, '0, "R2 disabled unit skipped");

      // Out-of-range unit number (R10)
      cfg(9, 0, 32'h3000);
      cfg(9, 1, 32'(mk_ctl(1, 2'b11, 0, 0, 0)));
      access(32'h3000, 0, 0, 0, '0, "R10 unit 9 ignored");
      cfg(1, 0, 32'h3000);
      cfg(1, 1, 32'(mk_ctl(1, 2'b11, 0, 0, 0)));
      access(32'h3000, 0, 0, 0, '0, "R10 unit 1 written");

      // Idle cycle (R9)
      @(negedge clk);
      acc_valid = 1'b0; acc_addr = 32'h3000;
      @(negedge clk);
      check(wp_hit == 0, "R9", $sformatf("%0d", wp_hit), "0");

      // Random mix
      for (int it = 0; it < 600; it++) begin
         if (it % 6 == 0) begin
            u = int'($urandom % 10);
            if ($urandom % 2 == 0)
               cfg(u, 0, 32'h4000 + ($urandom % 32'h1000));
            else
               cfg(u, 1, 32'(mk_ctl($urandom % 4 != 0, 2'($urandom),
                  int'($urandom % 12), $urandom % 4 == 0, int'($urandom % 6))));
         end
         a = 32'h4000 + ($urandom % 32'h1000);
         access(a, $urandom % 2 == 1, int'($urandom % 4), $urandom % 8 == 0,
                CN'($urandom), "R3/R4/R5/R6/R7/R8 random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule